// File: doc/BRIEF.md
# Byte-Lane Addressable Register File

This block holds the architectural registers of a small 16-bit processor: sixteen 16-bit entries, read through two combinational ports and written through two ports on the rising clock edge. Every port carries a 4-bit code and a flag. The flag says whether the code names a whole 16-bit register or an 8-bit view of one.

In 16-bit mode the code is the register index. Index 0 is a constant zero. Indices 1 to 10 are general registers. Indices 11 to 15 hold the stack pointer, the link register, the frame pointer, the page-table pointer and the trap-handler pointer.

In 8-bit mode the code selects one of three lane behaviours, and which one applies depends on the register the code lands on. Registers 1 to 5 expose their low and high bytes separately, and a byte write into one half keeps the other half intact. Registers 6 to 10 expose only a low byte, and a byte write into them clears the upper byte.

The second write port serves instructions that produce two results, such as a quotient with its remainder or a product split into two halves. When both write ports touch one register in the same cycle, port B's update is applied on top of port A's.

Top module: `lane_regfile`

## Requirements
- R1: In 8-bit mode, an odd code c in 1..9 reads the low byte of register (c+1)/2 and an even code c in 2..10 reads the high byte of register c/2. Every 8-bit read returns the byte in bits 7:0 with bits 15:8 at zero.
- R2: An 8-bit write through an odd code in 1..9 replaces only bits 7:0 of its register, and one through an even code in 2..10 replaces only bits 15:8 with write data bits 7:0. The other byte keeps its value.
- R3: 8-bit codes 11..15 map to registers 6..10. A read returns the low byte. A write stores write data bits 7:0 in bits 7:0 and zero in bits 15:8.
- R4: Register 0, whether reached by 16-bit code 0 or 8-bit code 0, always reads 0, and writes to it are discarded.
- R5: In 16-bit mode, code n (0..15) reads and writes register n in full. Codes 11 to 15 are the stack pointer, link, frame, page-table and trap-handler registers, in that order.
- R6: While rst is high at a rising edge, every register loads its reset value and any write is ignored. Registers 11 and 13 reset to 0xFFE0; all others, including register 15, reset to 0.
- R7: Both write ports may update different registers in the same cycle, and both updates take effect.
- R8: When both write ports hit one register in the same cycle, port A's update is applied first and port B's on top of it. Bits written by B take B's value, and bits written only by A take A's value.
- R9: A write port with its enable low changes no register. Reads are combinational, and a write becomes visible on the read ports right after the rising edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_wide | input | 1 | Read port A: 1 = 16-bit code, 0 = 8-bit code |
| rd_a_code | input | 4 | Read port A register code |
| rd_a_data | output | 16 | Read port A data (8-bit reads zero-extended) |
| rd_b_wide | input | 1 | Read port B: 1 = 16-bit code, 0 = 8-bit code |
| rd_b_code | input | 4 | Read port B register code |
| rd_b_data | output | 16 | Read port B data (8-bit reads zero-extended) |
| wr_a_en | input | 1 | Write port A enable |
| wr_a_wide | input | 1 | Write port A: 1 = 16-bit code, 0 = 8-bit code |
| wr_a_code | input | 4 | Write port A register code |
| wr_a_data | input | 16 | Write port A data (8-bit writes use bits 7:0) |
| wr_b_en | input | 1 | Write port B enable |
| wr_b_wide | input | 1 | Write port B: 1 = 16-bit code, 0 = 8-bit code |
| wr_b_code | input | 4 | Write port B register code |
| wr_b_data | input | 16 | Write port B data (8-bit writes use bits 7:0) |

## Verification
The two write ports can reach the same register on the same edge. The bench provokes this with several pairings: a full write on each port, a low-byte write on A with a high-byte write on B, two low-byte writes, a full write followed by a zero-extending byte write, and the reverse order. In each case the register is read back in 16-bit mode after the edge and compared with the value obtained by applying A's merge and then B's. This confirms that B wins on overlapping bits and that A survives on bits only A wrote. The reset path is also applied while a write is pending, to show that reset takes precedence.

// File: rtl/lrf_pkg.sv
package lrf_pkg;

  // How a port touches the 16-bit register it selects.
  typedef enum logic [1:0] {
    LANE_FULL = 2'd0,  // whole register
    LANE_LO   = 2'd1,  // low byte, high byte kept
    LANE_HI   = 2'd2,  // high byte, low byte kept
    LANE_ZX   = 2'd3   // low byte, high byte cleared on write
  } lane_e;

  // Indices of pointer registers with a non-zero reset value.
  localparam int unsigned STACK_IDX = 11;
  localparam int unsigned FRAME_IDX = 13;

endpackage

// File: rtl/lrf_decode.sv
module lrf_decode
  import lrf_pkg::*;
#(
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned SPLIT_REGS = 5
) (
  input  logic              wide,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] idx,
  output lane_e             lane
);

  localparam logic [CODE_W-1:0] SPLIT_LAST = CODE_W'(2 * SPLIT_REGS);
  localparam logic [CODE_W-1:0] ZX_OFFSET  = CODE_W'(SPLIT_REGS);

  logic [CODE_W:0] code_inc;
  assign code_inc = {1'b0, code} + 1'b1;

  always_comb begin
    idx  = '0;
    lane = LANE_FULL;
    if (wide) begin
      idx  = code;
      lane = LANE_FULL;
    end else if (code == '0) begin
      idx  = '0;
      lane = LANE_ZX;
    end else if (code <= SPLIT_LAST) begin
      idx  = code_inc[CODE_W:1];
      lane = code[0] ? LANE_LO : LANE_HI;
    end else begin
      idx  = code - ZX_OFFSET;
      lane = LANE_ZX;
    end
  end

endmodule

// File: rtl/lrf_read_port.sv
module lrf_read_port
  import lrf_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned SPLIT_REGS = 5,
  localparam int unsigned NREG      = 1 << CODE_W,
  localparam int unsigned BYTE_W    = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide,
  input  logic [CODE_W-1:0] code,
  input  logic [DATA_W-1:0] regs [NREG],
  output logic [DATA_W-1:0] data
);

  logic [CODE_W-1:0] idx;
  lane_e             lane;
  logic [DATA_W-1:0] src;

  lrf_decode #(.CODE_W(CODE_W), .SPLIT_REGS(SPLIT_REGS)) dec_i (
    .wide(wide), .code(code), .idx(idx), .lane(lane)
  );

  assign src = regs[idx];

  always_comb begin
    unique case (lane)
      LANE_FULL: data = src;
      LANE_HI:   data = {{BYTE_W{1'b0}}, src[DATA_W-1:BYTE_W]};
      default:   data = {{BYTE_W{1'b0}}, src[BYTE_W-1:0]};
    endcase
  end

  // R4: whatever selects entry 0 sees zero
  assert_zero_reg_R4: assert property (@(posedge clk) disable iff (rst)
    (idx == '0) |-> (data == '0));

  // R1 / R3: byte views never carry upper bits
  assert_byte_upper_R1: assert property (@(posedge clk) disable iff (rst)
    !wide |-> (data[DATA_W-1:BYTE_W] == '0));

endmodule

// File: rtl/lrf_reg_cell.sv
module lrf_reg_cell
  import lrf_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned IDX       = 1,
  parameter logic [DATA_W-1:0] RESET_VAL = '0,
  localparam int unsigned BYTE_W   = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic [CODE_W-1:0] a_idx,
  input  lane_e             a_lane,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_en,
  input  logic [CODE_W-1:0] b_idx,
  input  lane_e             b_lane,
  input  logic [DATA_W-1:0] b_data,
  output logic [DATA_W-1:0] q
);

  localparam logic [CODE_W-1:0] MY_IDX = CODE_W'(IDX);

  logic              a_hit, b_hit;
  logic [DATA_W-1:0] after_a, nxt;

  assign a_hit = a_en && (a_idx == MY_IDX);
  assign b_hit = b_en && (b_idx == MY_IDX);

  function automatic logic [DATA_W-1:0] merge(
    input logic [DATA_W-1:0] old,
    input lane_e             lane,
    input logic [DATA_W-1:0] d
  );
    logic [DATA_W-1:0] r;
    unique case (lane)
      LANE_FULL: r = d;
      LANE_LO:   r = {old[DATA_W-1:BYTE_W], d[BYTE_W-1:0]};
      LANE_HI:   r = {d[BYTE_W-1:0], old[BYTE_W-1:0]};
      default:   r = {{BYTE_W{1'b0}}, d[BYTE_W-1:0]};
    endcase
    return r;
  endfunction

  // Port A first, port B layered on top.
  always_comb begin
    after_a = a_hit ? merge(q, a_lane, a_data) : q;
    nxt     = b_hit ? merge(after_a, b_lane, b_data) : after_a;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VAL;
    else     q <= nxt;
  end

  assert_reset_value_R6: assert property (@(posedge clk)
    rst |=> (q == RESET_VAL));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(a_hit || b_hit) |=> $stable(q));

  assert_lo_keeps_hi_R2: assert property (@(posedge clk) disable iff (rst)
    (a_hit && a_lane == LANE_LO && !b_hit) |=>
      (q[DATA_W-1:BYTE_W] == $past(q[DATA_W-1:BYTE_W])));

  assert_hi_keeps_lo_R2: assert property (@(posedge clk) disable iff (rst)
    (a_hit && a_lane == LANE_HI && !b_hit) |=>
      (q[BYTE_W-1:0] == $past(q[BYTE_W-1:0])));

  assert_zx_clears_R3: assert property (@(posedge clk) disable iff (rst)
    ((a_hit && a_lane == LANE_ZX && !b_hit) || (b_hit && b_lane == LANE_ZX)) |=>
      (q[DATA_W-1:BYTE_W] == '0));

  assert_b_full_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (b_hit && b_lane == LANE_FULL) |=> (q == $past(b_data)));

endmodule

// File: rtl/lane_regfile.sv
module lane_regfile
  import lrf_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned SPLIT_REGS = 5,
  parameter logic [DATA_W-1:0] STACK_TOP = 16'hFFE0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_a_wide,
  input  logic [CODE_W-1:0] rd_a_code,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic              rd_b_wide,
  input  logic [CODE_W-1:0] rd_b_code,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_a_en,
  input  logic              wr_a_wide,
  input  logic [CODE_W-1:0] wr_a_code,
  input  logic [DATA_W-1:0] wr_a_data,
  input  logic              wr_b_en,
  input  logic              wr_b_wide,
  input  logic [CODE_W-1:0] wr_b_code,
  input  logic [DATA_W-1:0] wr_b_data
);

  localparam int unsigned NREG = 1 << CODE_W;

  logic [DATA_W-1:0] regs [NREG];
  logic [CODE_W-1:0] wa_idx, wb_idx;
  lane_e             wa_lane, wb_lane;

  lrf_decode #(.CODE_W(CODE_W), .SPLIT_REGS(SPLIT_REGS)) wa_dec_i (
    .wide(wr_a_wide), .code(wr_a_code), .idx(wa_idx), .lane(wa_lane)
  );

  lrf_decode #(.CODE_W(CODE_W), .SPLIT_REGS(SPLIT_REGS)) wb_dec_i (
    .wide(wr_b_wide), .code(wr_b_code), .idx(wb_idx), .lane(wb_lane)
  );

  // Entry 0 has no storage.
  assign regs[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_cell
    localparam logic [DATA_W-1:0] RV =
      (i == STACK_IDX || i == FRAME_IDX) ? STACK_TOP : '0;
    lrf_reg_cell #(
      .DATA_W(DATA_W), .CODE_W(CODE_W), .IDX(i), .RESET_VAL(RV)
    ) cell_i (
      .clk(clk), .rst(rst),
      .a_en(wr_a_en), .a_idx(wa_idx), .a_lane(wa_lane), .a_data(wr_a_data),
      .b_en(wr_b_en), .b_idx(wb_idx), .b_lane(wb_lane), .b_data(wr_b_data),
      .q(regs[i])
    );
  end

  lrf_read_port #(.DATA_W(DATA_W), .CODE_W(CODE_W), .SPLIT_REGS(SPLIT_REGS)) rd_a_i (
    .clk(clk), .rst(rst), .wide(rd_a_wide), .code(rd_a_code),
    .regs(regs), .data(rd_a_data)
  );

  lrf_read_port #(.DATA_W(DATA_W), .CODE_W(CODE_W), .SPLIT_REGS(SPLIT_REGS)) rd_b_i (
    .clk(clk), .rst(rst), .wide(rd_b_wide), .code(rd_b_code),
    .regs(regs), .data(rd_b_data)
  );

endmodule

// File: tb/lane_regfile_tb.sv
module lane_regfile_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC       = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_a_wide = 1'b1, rd_b_wide = 1'b1;
  logic [3:0]  rd_a_code = '0, rd_b_code = '0;
  logic [15:0] rd_a_data, rd_b_data;
  logic        wr_a_en = 1'b0, wr_a_wide = 1'b0, wr_b_en = 1'b0, wr_b_wide = 1'b0;
  logic [3:0]  wr_a_code = '0, wr_b_code = '0;
  logic [15:0] wr_a_data = '0, wr_b_data = '0;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_regfile dut_i (
    .clk(clk), .rst(rst),
    .rd_a_wide(rd_a_wide), .rd_a_code(rd_a_code), .rd_a_data(rd_a_data),
    .rd_b_wide(rd_b_wide), .rd_b_code(rd_b_code), .rd_b_data(rd_b_data),
    .wr_a_en(wr_a_en), .wr_a_wide(wr_a_wide), .wr_a_code(wr_a_code), .wr_a_data(wr_a_data),
    .wr_b_en(wr_b_en), .wr_b_wide(wr_b_wide), .wr_b_code(wr_b_code), .wr_b_data(wr_b_data)
  );

  typedef struct packed {
    logic        a_en;   logic a_wide; logic [3:0] a_code; logic [15:0] a_data;
    logic        b_en;   logic b_wide; logic [3:0] b_code; logic [15:0] b_data;
    logic        x_wide; logic [3:0] x_code; logic [15:0] x_exp;
    logic        y_wide; logic [3:0] y_code; logic [15:0] y_exp;
    logic [3:0]  req;
  } vec_t;

  // Each row: writes, one edge, then two reads checked. Byte codes: 1/2 = r1 lo/hi,
  // 3/4 = r2, 9/10 = r5, 11 = r6 view, 15 = r10 view.
  localparam vec_t VECS [NVEC] = '{
    // R5: specials after reset through 16-bit codes
    '{1'b0,1'b0,4'd0,16'h0000, 1'b0,1'b0,4'd0,16'h0000, 1'b1,4'd11,16'hFFE0, 1'b1,4'd13,16'hFFE0, 4'd5},
    // R5 full write r1; R1 low byte view
    '{1'b1,1'b1,4'd1,16'h1234, 1'b0,1'b0,4'd0,16'h0000, 1'b1,4'd1,16'h1234, 1'b0,4'd1,16'h0034, 4'd5},
    // R2 high half write keeps low
    '{1'b1,1'b0,4'd2,16'h00AB, 1'b0,1'b0,4'd0,16'h0000, 1'b1,4'd1,16'hAB34, 1'b0,4'd2,16'h00AB, 4'd2},
    // R2 low half write keeps high
    '{1'b1,1'b0,4'd1,16'hEECD, 1'b0,1'b0,4'd0,16'h0000, 1'b1,4'd1,16'hABCD, 1'b0,4'd1,16'h00CD, 4'd2},
    // R3 byte view read of r6
    '{1'b1,1'b1,4'd6,16'hBEEF, 1'b0,1'b0,4'd0,16'h0000, 1'b1,4'd6,16'hBEEF, 1'b0,4'd11,16'h00EF, 4'd3},
    // R3 byte write clears high
    '{1'b1,1'b0,4'd11,16'h1177, 1'b0,1'b0,4'd0,16'h0000, 1'b1,4'd6,16'h0077, 1'b0,4'd11,16'h0077, 4'd3},
    // R4 write to r0 discarded
    '{1'b1,1'b1,4'd0,16'hFFFF, 1'b0,1'b0,4'd0,16'h0000, 1'b1,4'd0,16'h0000, 1'b0,4'd0,16'h0000, 4'd4},
    // R7 link and trap handler in one cycle
    '{1'b1,1'b1,4'd12,16'h4242, 1'b1,1'b1,4'd15,16'h0100, 1'b1,4'd12,16'h4242, 1'b1,4'd15,16'h0100, 4'd7},
    // R8 both full on r2: B wins
    '{1'b1,1'b1,4'd2,16'h1111, 1'b1,1'b1,4'd2,16'h2222, 1'b1,4'd2,16'h2222, 1'b0,4'd3,16'h0022, 4'd8},
    // R8 A low + B high on r2: both land
    '{1'b1,1'b0,4'd3,16'h0055, 1'b1,1'b0,4'd4,16'h0066, 1'b1,4'd2,16'h6655, 1'b0,4'd4,16'h0066, 4'd8},
    // R8 both low on r5: B wins
    '{1'b1,1'b0,4'd9,16'h0012, 1'b1,1'b0,4'd9,16'h0034, 1'b1,4'd5,16'h0034, 1'b0,4'd10,16'h0000, 4'd8},
    // R5 page table write, stack untouched
    '{1'b1,1'b1,4'd14,16'hABCD, 1'b0,1'b0,4'd0,16'h0000, 1'b1,4'd14,16'hABCD, 1'b1,4'd11,16'hFFE0, 4'd5},
    // R9 disabled ports change nothing
    '{1'b0,1'b1,4'd1,16'h9999, 1'b0,1'b1,4'd14,16'h9999, 1'b1,4'd1,16'hABCD, 1'b1,4'd14,16'hABCD, 4'd9},
    // R8 A full then B zero-extend on r10
    '{1'b1,1'b1,4'd10,16'h8001, 1'b1,1'b0,4'd15,16'h55FF, 1'b1,4'd10,16'h00FF, 1'b0,4'd15,16'h00FF, 4'd8},
    // R8 A zero-extend then B full on r10
    '{1'b1,1'b0,4'd15,16'h0033, 1'b1,1'b1,4'd10,16'h7700, 1'b1,4'd10,16'h7700, 1'b0,4'd15,16'h0000, 4'd8}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  endtask

  task automatic set_reads(input logic aw, input logic [3:0] ac,
                           input logic bw, input logic [3:0] bc);
    rd_a_wide = aw; rd_a_code = ac; rd_b_wide = bw; rd_b_code = bc;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R6 reset values
    set_reads(1'b1, 4'd11, 1'b1, 4'd13); #1;
    check("R6 stack", rd_a_data, 16'hFFE0);
    check("R6 frame", rd_b_data, 16'hFFE0);
    set_reads(1'b1, 4'd15, 1'b1, 4'd1); #1;
    check("R6 trap handler", rd_a_data, 16'h0000);
    check("R6 r1", rd_b_data, 16'h0000);
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      wr_a_en = VECS[v].a_en; wr_a_wide = VECS[v].a_wide;
      wr_a_code = VECS[v].a_code; wr_a_data = VECS[v].a_data;
      wr_b_en = VECS[v].b_en; wr_b_wide = VECS[v].b_wide;
      wr_b_code = VECS[v].b_code; wr_b_data = VECS[v].b_data;
      set_reads(VECS[v].x_wide, VECS[v].x_code, VECS[v].y_wide, VECS[v].y_code);
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d vec%0d port A", VECS[v].req, v), rd_a_data, VECS[v].x_exp);
      check($sformatf("R%0d vec%0d port B", VECS[v].req, v), rd_b_data, VECS[v].y_exp);
    end
    wr_a_en = 1'b0; wr_b_en = 1'b0;

    // R1 high byte of r1 read back as low byte (r1 = ABCD)
    set_reads(1'b0, 4'd2, 1'b0, 4'd4); #1;
    check("R1 r1 high view", rd_a_data, 16'h00AB);
    check("R1 r2 high view", rd_b_data, 16'h0066);

    // R9 write not visible before its edge
    @(negedge clk);
    wr_a_en = 1'b1; wr_a_wide = 1'b1; wr_a_code = 4'd3; wr_a_data = 16'hC0DE;
    set_reads(1'b1, 4'd3, 1'b1, 4'd3); #1;
    check("R9 before edge", rd_a_data, 16'h0000);
    @(posedge clk); @(negedge clk);
    wr_a_en = 1'b0;
    check("R9 after edge", rd_a_data, 16'hC0DE);

    // R6 reset overrides a pending write and restores everything
    wr_a_en = 1'b1; wr_a_wide = 1'b1; wr_a_code = 4'd1; wr_a_data = 16'h5555;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0; wr_a_en = 1'b0;
    set_reads(1'b1, 4'd1, 1'b1, 4'd11); #1;
    check("R6 r1 after reset with write", rd_a_data, 16'h0000);
    check("R6 stack after reset", rd_b_data, 16'hFFE0);
    set_reads(1'b1, 4'd12, 1'b1, 4'd15); #1;
    check("R6 link after reset", rd_a_data, 16'h0000);
    check("R6 trap after reset", rd_b_data, 16'h0000);
    set_reads(1'b1, 4'd13, 1'b1, 4'd10); #1;
    check("R6 frame after reset", rd_a_data, 16'hFFE0);
    check("R6 r10 after reset", rd_b_data, 16'h0000);

    finish_run();
  end

endmodule